// File: doc/BRIEF.md
# GCI Layer-1 Serial Frame Port

This block is the layer-1 end of a GCI (IOM-2 style) serial bus. The block is clocked by the bus clock, which runs at twice the data rate. Each bit period is therefore two clock cycles, and the block tracks the bit phase with an internal half-bit counter instead of a separate divided clock. The receive section and the transmit section each have their own frame sync input. Each section counts its own frame from its own sync pulse. A section that sees no further sync keeps running frames of the current length.

The receive section turns the 32 bits of a frame into four parallel bytes, in this order: B1, B2, monitor and control. It presents them together with a one-cycle frame-done strobe. The transmit section latches four outgoing bytes and a per-byte enable mask at the start of each frame, then shifts them out MSB first. It drives the line only in the enabled byte slots and releases it to the idle (high-impedance) state everywhere else. The output is an open-drain style data/enable pair.

In the multiplexed mode the frame is eight times longer and carries eight 32-bit subframes, one for each attached device. A device-select input picks the one subframe this port uses. A single-rate bit clock output is provided for attached devices that cannot use the double-rate clock.

Top module: `gci_port`

## Requirements
- R1: After reset, and in each section until that section's first sync, the outputs are idle: tx_oe_o=0, tx_data_o=1, rx_done_o=0, bit_clk_o=0, and all received bytes are 0.
- R2: A frame lasts 32 bits (64 clock cycles) in normal mode (mux_mode_i=0) and 256 bits (512 clock cycles) in multiplexed mode (mux_mode_i=1). Without a new sync, the next frame starts directly after the last cycle of the current one.
- R3: A sync sampled high at a rising clock edge restarts that section's frame. The following clock cycle is the first half of bit 0, and bit k occupies cycles 2k and 2k+1 of the frame. bit_clk_o is 1 in the first half of each receive bit and 0 in the second half.
- R4: rx_data_i is sampled at the edge that ends the first half of each bit. Within a 32-bit subframe, bits 0-7 go to rx_b1_o, bits 8-15 to rx_b2_o, bits 16-23 to rx_mon_o and bits 24-31 to rx_ctl_o. The first bit of each byte is the MSB. The control byte carries the D bits in [7:6], the C/I code in [5:2] and the handshake bits in [1:0].
- R5: rx_done_o is high for exactly the one cycle that follows the last clock cycle of a receive frame. The received bytes change only at that same edge and hold otherwise.
- R6: Transmit bit k is held on tx_data_o for both halves of bit k, MSB of each byte first. tx_oe_o is 1 only inside a byte slot whose enable bit is set: tx_slot_en_i[0] enables B1, [1] B2, [2] monitor and [3] control. Whenever tx_oe_o is 0, tx_data_o is 1.
- R7: The transmit bytes, the slot enables, mux_mode_i and dev_sel_i are latched when a frame starts, either at a sync or at a wrap. Changing them during a frame does not affect that frame.
- R8: In multiplexed mode, subframe d covers frame bits 32d to 32d+31. The port receives and transmits only in subframe d = dev_sel_i. In all other subframes tx_oe_o stays 0 and rx_data_i is ignored.
- R9: In normal mode dev_sel_i has no effect.
- R10: The receive and transmit sections are timed only by their own sync. A transmit sync alone starts transmission but does not start reception, frame-done strobes or bit_clk_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_mode_i | input | 1 | 0 normal 32-bit frame, 1 eight-device multiplexed frame |
| dev_sel_i | input | 3 | Subframe used in multiplexed mode |
| rx_sync_i | input | 1 | Receive frame sync pulse |
| rx_data_i | input | 1 | Serial receive data |
| tx_sync_i | input | 1 | Transmit frame sync pulse |
| tx_b1_i | input | 8 | Outgoing B1 byte |
| tx_b2_i | input | 8 | Outgoing B2 byte |
| tx_mon_i | input | 8 | Outgoing monitor byte |
| tx_ctl_i | input | 8 | Outgoing control byte (D, C/I, handshake) |
| tx_slot_en_i | input | 4 | Per-byte transmit enable |
| rx_b1_o | output | 8 | Received B1 byte |
| rx_b2_o | output | 8 | Received B2 byte |
| rx_mon_o | output | 8 | Received monitor byte |
| rx_ctl_o | output | 8 | Received control byte |
| rx_done_o | output | 1 | One-cycle receive frame-done strobe |
| tx_data_o | output | 1 | Serial transmit data, 1 when released |
| tx_oe_o | output | 1 | Transmit drive enable (0 = high impedance) |
| bit_clk_o | output | 1 | Single-rate bit clock for attached devices |

## Verification
Counted from the rising edge that samples a sync, transmit bit k is due in cycles 2k+1 and 2k+2, with bit_clk_o high in the first of the two. The receive bit for that position is taken at the edge that ends cycle 2k+1. The received bytes and rx_done_o appear one cycle after the frame's last cycle, that is, 65 or 513 cycles after the sync edge. The bench drives every input and samples every output at the falling clock edge. It steps once per half-bit from the sync edge and checks each output in the exact cycle given by this count. It changes the latched inputs in the middle of the frame and checks that the current frame does not change.

// File: rtl/gci_pkg.sv
package gci_pkg;

    localparam int SUB_BITS  = 32;                          // bits per device subframe
    localparam int N_DEV     = 8;                           // devices in multiplexed frame
    localparam int BYTE_W    = 8;
    localparam int N_SLOT    = SUB_BITS / BYTE_W;           // byte slots per subframe
    localparam int SUB_W     = $clog2(SUB_BITS);
    localparam int DEV_W     = $clog2(N_DEV);
    localparam int CNT_W     = $clog2(2 * SUB_BITS * N_DEV); // half-bit counter
    localparam int BIT_W     = CNT_W - 1;
    localparam int SLOT_W    = $clog2(N_SLOT);

    // Channel bytes of one subframe, first-sent byte in the upper bits
    typedef struct packed {
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b2;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] ctl;
    } chan_word_t;

    // Where a section currently stands inside its frame
    typedef struct packed {
        logic             active;  // a sync has been seen
        logic             half;    // 0 first half of bit, 1 second half
        logic             sel;     // current bit belongs to this port
        logic [SUB_W-1:0] pos;     // bit position inside the subframe
    } slot_pos_t;

    function automatic logic [CNT_W-1:0] frame_last(input logic mux);
        return mux ? CNT_W'(2 * SUB_BITS * N_DEV - 1) : CNT_W'(2 * SUB_BITS - 1);
    endfunction

endpackage

// File: rtl/gci_frame_timer.sv
module gci_frame_timer
    import gci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic             mux_i,
    input  logic [DEV_W-1:0] sel_i,
    output slot_pos_t        pos_o,
    output logic             start_o,
    output logic             end_o
);

    logic             act_q;
    logic             mode_q;
    logic [DEV_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic [BIT_W-1:0] bitno;

    always_comb begin
        last         = frame_last(mode_q);
        end_o        = act_q && (cnt_q == last);
        start_o      = sync_i || end_o;
        bitno        = cnt_q[CNT_W-1:1];
        pos_o.active = act_q;
        pos_o.half   = cnt_q[0];
        pos_o.pos    = bitno[SUB_W-1:0];
        pos_o.sel    = !mode_q || (bitno[BIT_W-1:SUB_W] == sel_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            mode_q <= 1'b0;
            sel_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (sync_i)
                act_q <= 1'b1;
            if (start_o) begin
                cnt_q  <= '0;
                mode_q <= mux_i;
                sel_q  <= sel_i;
            end else if (act_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: a sync restarts the frame at bit 0, first half
    a_r3_sync_restart: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (act_q && cnt_q == '0));

    // R2: a normal-mode frame never runs past 64 half-bits
    a_r2_normal_bound: assert property (@(posedge clk) disable iff (rst)
        (act_q && !mode_q) |-> (cnt_q < CNT_W'(2 * SUB_BITS)));

    // R2: inside a frame the half-bit count advances by one per clock
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (act_q && !start_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/gci_rx_deframer.sv
module gci_rx_deframer
    import gci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_pos_t  pos_i,
    input  logic       end_i,
    input  logic       rx_data_i,
    output chan_word_t word_o,
    output logic       done_o
);

    logic [SUB_BITS-1:0] asm_q;
    logic [SUB_W-1:0]    idx;

    assign idx = SUB_W'(SUB_BITS - 1) - pos_i.pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q  <= '0;
            word_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= end_i;
            if (end_i)
                word_o <= chan_word_t'(asm_q);
            if (pos_i.active && !pos_i.half && pos_i.sel)
                asm_q[idx] <= rx_data_i;
        end
    end

    // R5: the frame-done strobe lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5: received bytes only move together with the strobe
    a_r5_word_hold: assert property (@(posedge clk) disable iff (rst)
        !end_i |=> $stable(word_o));

    // R1: no strobe before the receive section has seen a sync
    a_r1_no_early_done: assert property (@(posedge clk) disable iff (rst)
        !pos_i.active |=> !done_o);

endmodule

// File: rtl/gci_tx_framer.sv
module gci_tx_framer
    import gci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_pos_t         pos_i,
    input  logic              start_i,
    input  chan_word_t        word_i,
    input  logic [N_SLOT-1:0] en_i,
    output logic              tx_data_o,
    output logic              tx_oe_o
);

    logic [SUB_BITS-1:0] word_q;
    logic [N_SLOT-1:0]   en_q;
    logic [SUB_W-1:0]    idx;
    logic [SLOT_W-1:0]   slot;
    logic                unused_half;

    assign unused_half = pos_i.half;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            en_q   <= '0;
        end else if (start_i) begin
            word_q <= word_i;
            en_q   <= en_i;
        end
    end

    always_comb begin
        idx       = SUB_W'(SUB_BITS - 1) - pos_i.pos;
        slot      = pos_i.pos[SUB_W-1 -: SLOT_W];
        tx_oe_o   = pos_i.active && pos_i.sel && en_q[slot];
        tx_data_o = tx_oe_o ? word_q[idx] : 1'b1;
    end

    // R1: line released until the transmit section has seen a sync
    a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
        !pos_i.active |-> (!tx_oe_o && tx_data_o));

    // R6: a released line always reads high
    a_r6_release_high: assert property (@(posedge clk) disable iff (rst)
        !tx_oe_o |-> tx_data_o);

    // R3: each bit is held through both halves of its period
    a_r3_bit_held: assert property (@(posedge clk) disable iff (rst)
        pos_i.half |-> ($stable(tx_data_o) && $stable(tx_oe_o)));

    // R7: outgoing bytes and enables only change at a frame start
    a_r7_latched: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(word_q) && $stable(en_q)));

endmodule

// File: rtl/gci_port.sv
module gci_port
    import gci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mux_mode_i,
    input  logic [DEV_W-1:0]  dev_sel_i,
    input  logic              rx_sync_i,
    input  logic              rx_data_i,
    input  logic              tx_sync_i,
    input  logic [BYTE_W-1:0] tx_b1_i,
    input  logic [BYTE_W-1:0] tx_b2_i,
    input  logic [BYTE_W-1:0] tx_mon_i,
    input  logic [BYTE_W-1:0] tx_ctl_i,
    input  logic [N_SLOT-1:0] tx_slot_en_i,
    output logic [BYTE_W-1:0] rx_b1_o,
    output logic [BYTE_W-1:0] rx_b2_o,
    output logic [BYTE_W-1:0] rx_mon_o,
    output logic [BYTE_W-1:0] rx_ctl_o,
    output logic              rx_done_o,
    output logic              tx_data_o,
    output logic              tx_oe_o,
    output logic              bit_clk_o
);

    slot_pos_t  rx_pos, tx_pos;
    logic       rx_start, rx_end, tx_start, tx_end;
    chan_word_t rx_word, tx_word;

    gci_frame_timer u_rx_timer (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (rx_sync_i),
        .mux_i   (mux_mode_i),
        .sel_i   (dev_sel_i),
        .pos_o   (rx_pos),
        .start_o (rx_start),
        .end_o   (rx_end)
    );

    gci_frame_timer u_tx_timer (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (tx_sync_i),
        .mux_i   (mux_mode_i),
        .sel_i   (dev_sel_i),
        .pos_o   (tx_pos),
        .start_o (tx_start),
        .end_o   (tx_end)
    );

    gci_rx_deframer u_rx (
        .clk       (clk),
        .rst       (rst),
        .pos_i     (rx_pos),
        .end_i     (rx_end),
        .rx_data_i (rx_data_i),
        .word_o    (rx_word),
        .done_o    (rx_done_o)
    );

    assign tx_word = '{b1: tx_b1_i, b2: tx_b2_i, mon: tx_mon_i, ctl: tx_ctl_i};

    gci_tx_framer u_tx (
        .clk       (clk),
        .rst       (rst),
        .pos_i     (tx_pos),
        .start_i   (tx_start),
        .word_i    (tx_word),
        .en_i      (tx_slot_en_i),
        .tx_data_o (tx_data_o),
        .tx_oe_o   (tx_oe_o)
    );

    assign rx_b1_o   = rx_word.b1;
    assign rx_b2_o   = rx_word.b2;
    assign rx_mon_o  = rx_word.mon;
    assign rx_ctl_o  = rx_word.ctl;
    assign bit_clk_o = rx_pos.active && !rx_pos.half;

    // R10: the receive start never comes from the transmit sync alone
    a_r10_rx_own_sync: assert property (@(posedge clk) disable iff (rst)
        (rx_start && !rx_end) |-> rx_sync_i);

    // R10: the transmit start never comes from the receive sync alone
    a_r10_tx_own_sync: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !tx_end) |-> tx_sync_i);

endmodule

// File: tb/test_gci_port.sv
`timescale 1ns/1ps
module test_gci_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mux_mode_i = 1'b0;
    logic [2:0] dev_sel_i = '0;
    logic       rx_sync_i = 1'b0;
    logic       rx_data_i = 1'b0;
    logic       tx_sync_i = 1'b0;
    logic [7:0] tx_b1_i = '0, tx_b2_i = '0, tx_mon_i = '0, tx_ctl_i = '0;
    logic [3:0] tx_slot_en_i = '0;
    logic [7:0] rx_b1_o, rx_b2_o, rx_mon_o, rx_ctl_o;
    logic       rx_done_o, tx_data_o, tx_oe_o, bit_clk_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gci_port i_gci_port (
        .clk(clk), .rst(rst), .mux_mode_i(mux_mode_i), .dev_sel_i(dev_sel_i),
        .rx_sync_i(rx_sync_i), .rx_data_i(rx_data_i), .tx_sync_i(tx_sync_i),
        .tx_b1_i(tx_b1_i), .tx_b2_i(tx_b2_i), .tx_mon_i(tx_mon_i), .tx_ctl_i(tx_ctl_i),
        .tx_slot_en_i(tx_slot_en_i), .rx_b1_o(rx_b1_o), .rx_b2_o(rx_b2_o),
        .rx_mon_o(rx_mon_o), .rx_ctl_o(rx_ctl_o), .rx_done_o(rx_done_o),
        .tx_data_o(tx_data_o), .tx_oe_o(tx_oe_o), .bit_clk_o(bit_clk_o)
    );

    // vector: {mux, dev_sel, slot_en, tx word (B1..CTL), rx word (B1..CTL)}
    localparam logic [71:0] VEC [7] = '{
        {1'b0, 3'd0, 4'hF, 32'hA5C33C5A, 32'h12345678},
        {1'b0, 3'd5, 4'h5, 32'h0F0FF0F0, 32'hDEADBEEF},   // R9: dev_sel ignored
        {1'b0, 3'd0, 4'h0, 32'hFFFFFFFF, 32'h00000000},
        {1'b1, 3'd0, 4'hF, 32'h81422418, 32'hC0FFEE11},
        {1'b1, 3'd7, 4'h9, 32'h5A5A5A5A, 32'h8BADF00D},
        {1'b1, 3'd3, 4'h6, 32'h13579BDF, 32'h2468ACE0},
        {1'b0, 3'd2, 4'hA, 32'hFEDCBA98, 32'h7F00FF81}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after a falling edge.
    task automatic run_frame(input logic [71:0] v);
        logic        mux;
        logic [2:0]  sel;
        logic [3:0]  en;
        logic [31:0] txw, rxw;
        int          nb;
        mux = v[71]; sel = v[70:68]; en = v[67:64]; txw = v[63:32]; rxw = v[31:0];
        nb  = mux ? 256 : 32;
        mux_mode_i = mux; dev_sel_i = sel; tx_slot_en_i = en;
        {tx_b1_i, tx_b2_i, tx_mon_i, tx_ctl_i} = txw;
        rx_sync_i = 1'b1; tx_sync_i = 1'b1;
        for (int j = 0; j < 2 * nb; j++) begin
            logic [7:0] b;
            logic [4:0] ib;
            logic       selected, exp_oe, exp_d;
            @(negedge clk);
            rx_sync_i = 1'b0; tx_sync_i = 1'b0;
            b        = 8'(j >> 1);
            ib       = b[4:0];
            selected = !mux || (b[7:5] == sel);
            rx_data_i = selected ? rxw[5'd31 - ib] : (b[0] ^ b[3] ^ j[0]);
            exp_oe   = selected && en[ib[4:3]];
            exp_d    = exp_oe ? txw[5'd31 - ib] : 1'b1;
            if (j == 6) begin   // R7: late changes must not reach this frame
                mux_mode_i = ~mux; dev_sel_i = ~sel; tx_slot_en_i = ~en;
                {tx_b1_i, tx_b2_i, tx_mon_i, tx_ctl_i} = ~txw;
            end
            chk(mux ? "R8 R7" : "R6 R9 R7", "tx_oe_o", 32'(tx_oe_o), 32'(exp_oe));
            chk(mux ? "R8 R6" : "R6 R3", "tx_data_o", 32'(tx_data_o), 32'(exp_d));
            chk("R3", "bit_clk_o", 32'(bit_clk_o), 32'(j % 2 == 0));
            chk("R5", "rx_done_o inside frame", 32'(rx_done_o), 32'd0);
        end
        @(negedge clk);
        chk("R5", "rx_done_o at frame end", 32'(rx_done_o), 32'd1);
        chk(mux ? "R4 R8" : "R4", "rx bytes",
            {rx_b1_o, rx_b2_o, rx_mon_o, rx_ctl_o}, rxw);
        chk("R4", "control byte C/I field", 32'(rx_ctl_o[5:2]), 32'(rxw[5:2]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle state after reset, no sync seen yet
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R1", "tx_oe_o idle", 32'(tx_oe_o), 32'd0);
            chk("R1", "tx_data_o idle", 32'(tx_data_o), 32'd1);
            chk("R1", "rx_done_o idle", 32'(rx_done_o), 32'd0);
            chk("R1", "bit_clk_o idle", 32'(bit_clk_o), 32'd0);
            chk("R1", "rx bytes", {rx_b1_o, rx_b2_o, rx_mon_o, rx_ctl_o}, 32'd0);
        end

        // R10: transmit sync alone; R2: transmit wraps after 64 cycles on its own
        tx_slot_en_i = 4'hF;
        {tx_b1_i, tx_b2_i, tx_mon_i, tx_ctl_i} = 32'hA5_3C_0F_96;
        tx_sync_i = 1'b1;
        for (int j = 0; j < 80; j++) begin
            @(negedge clk);
            tx_sync_i = 1'b0;
            chk("R10 R2", "tx_oe_o after tx sync", 32'(tx_oe_o), 32'd1);
            chk("R10 R2", "tx_data_o after tx sync", 32'(tx_data_o),
                32'(32'hA5_3C_0F_96 >> (31 - ((j % 64) >> 1)) & 1));
            chk("R10", "rx_done_o without rx sync", 32'(rx_done_o), 32'd0);
            chk("R10", "bit_clk_o without rx sync", 32'(bit_clk_o), 32'd0);
        end

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 7; i++)
            run_frame(VEC[i]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule